// File: doc/BRIEF.md
# Prioritized Transfer Request Queue Arbiter

This block sits between a set of transfer requesters and a bank of transfer engines. A request is a tag plus two pieces of routing information. The first is a priority level, which selects one of several FIFOs. The second is a requester class: channel-triggered, generic master, or quick/L2-initiated. Each priority FIFO feeds its own engine port, and that port uses a ready/valid handshake. The engine ports drain independently and in parallel. Each port presents one request at a time, taken in arrival order.

Within each priority, every class has a 3-bit quota that caps how many of its requests may sit in that queue. The three quotas of one priority may not add up to more than 16. A request whose class has no room in its target queue stalls the single intake port, and this blocks all priorities until room appears. A slot becomes free at the moment its request is handed to the engine. A dispatch in the same cycle can therefore make room for a request that would otherwise stall.

Quotas are set by a configuration write. The write is taken only while the targeted queue is empty and the new quotas fit within the cap. A separate status bit reports each kind of refusal.

Top module: `xfer_queue_arb`

## Requirements
- R1: After reset every engine port shows out_valid low, every quota is 5, req_ready is high for classes 0 to 2, and err_zero_quota and both refusal bits are low.
- R2: A configuration write (cfg_we) sets the three quotas of priority cfg_prio from cfg_quota. Class 0 takes bits [2:0], class 1 takes bits [5:3] and class 2 takes bits [8:6]. The write takes effect only when that queue is empty and is not receiving a request in the same cycle, and only when the three fields sum to 16 or less.
- R3: A write whose fields sum to more than 16 leaves the quotas unchanged. After that write, cfg_sum_rej is 1 and cfg_busy_rej is 0.
- R4: A write to a queue that holds a request, or that receives one in that cycle, is ignored. After that write, cfg_busy_rej is 1 and cfg_sum_rej is 0. An accepted write clears both bits.
- R5: req_ready is high when the class's occupancy in the target priority is below its quota. Otherwise req_ready is low. A request is taken on a cycle with req_valid and req_ready both high.
- R6: A request whose class is at its quota is still taken if, in the same cycle, that priority's port dispatches a request of the same class.
- R7: Each priority port presents its requests strictly in the order they were taken. The port shows the request's tag on out_tag and its class on out_cls.
- R8: A priority port keeps its presented request stable until out_ready takes it. Different ports dispatch independently, in the same cycle if their out_ready inputs allow it.
- R9: A dispatch frees that class's slot. A request of the same class is then taken in the next cycle.
- R10: A request to a priority whose quota for that class is 0 is never taken, and err_zero_quota rises one cycle later and stays high until reset.
- R11: Class code 3 is never taken by any queue, and presenting it sets err_zero_quota.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_prio | input | 2 | Target priority queue |
| req_class | input | 2 | Requester class (0..2) |
| req_tag | input | 32 | Request payload tag |
| req_ready | output | 1 | Request taken this cycle if valid |
| cfg_we | input | 1 | Quota write strobe |
| cfg_prio | input | 2 | Priority whose quotas are written |
| cfg_quota | input | 9 | Three 3-bit quotas, class 0 in the low bits |
| cfg_busy_rej | output | 1 | Last write refused: queue not empty |
| cfg_sum_rej | output | 1 | Last write refused: quota sum above 16 |
| err_zero_quota | output | 1 | Sticky: request seen for a zero quota or class 3 |
| out_valid | output | 4 | Per-priority engine port valid |
| out_ready | input | 4 | Per-priority engine port ready |
| out_tag | output | 128 | Per-priority head tag, priority p at bits [32p+31:32p] |
| out_cls | output | 8 | Per-priority head class, priority p at bits [2p+1:2p] |

## Verification
An occupancy counter that drifts from the true queue contents does not change any data at the ports. It shows up as a wrong req_ready level: either a premature stall or an intake past quota. The bench compares req_ready with a model in every cycle, so a counter that is off by one is caught as soon as the stream of requests of that class reaches the quota. A FIFO pointer fault shows up as a wrong out_tag on the very next dispatch. A wrong refusal decision shows up one cycle after the write, in the status bits. From then on it also changes the stall pattern.

// File: rtl/xqa_pkg.sv
package xqa_pkg;
  localparam int NUM_CLS = 3;
  localparam int CLS_W   = 2;
  localparam int QW      = 3;
  localparam int QCFG_W  = NUM_CLS * QW;
  localparam int SUM_W   = QW + 2;

  function automatic logic [SUM_W-1:0] quota_sum(input logic [QCFG_W-1:0] f);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int c = 0; c < NUM_CLS; c++) s = s + SUM_W'(f[c*QW +: QW]);
    return s;
  endfunction
endpackage

// File: rtl/xqa_fifo.sv
module xqa_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign head     = mem[rd_ptr];
  assign nonempty = (fill != '0);
  assign full     = (fill == CW'(DEPTH));

  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  // R8
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> nonempty);
endmodule

// File: rtl/xqa_quota.sv
module xqa_quota
  import xqa_pkg::*;
#(
  parameter int MAX_SUM   = 16,
  parameter int RST_QUOTA = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [QCFG_W-1:0] cfg_q,
  input  logic              q_idle,
  input  logic              adm_fire,
  input  logic [CLS_W-1:0]  adm_cls,
  input  logic              dsp_fire,
  input  logic [CLS_W-1:0]  dsp_cls,
  output logic [NUM_CLS-1:0] room,
  output logic [NUM_CLS-1:0] zero,
  output logic              busy_hit,
  output logic              sum_hit
);
  localparam int CW = QW + 1;

  logic [NUM_CLS-1:0][QW-1:0] quota_q;
  logic [CW-1:0]              occ [NUM_CLS];
  logic                       sum_bad, apply;

  assign sum_bad  = quota_sum(cfg_q) > SUM_W'(MAX_SUM);
  assign busy_hit = cfg_we && !q_idle;
  assign sum_hit  = cfg_we && q_idle && sum_bad;
  assign apply    = cfg_we && q_idle && !sum_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CLS; c++) quota_q[c] <= QW'(RST_QUOTA);
    end else if (apply) begin
      for (int c = 0; c < NUM_CLS; c++) quota_q[c] <= cfg_q[c*QW +: QW];
    end
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic inc, dec;
    assign inc = adm_fire && (adm_cls == CLS_W'(c));
    assign dec = dsp_fire && (dsp_cls == CLS_W'(c));

    always_ff @(posedge clk) begin
      if (rst) occ[c] <= '0;
      else case ({inc, dec})
        2'b10:   occ[c] <= occ[c] + 1'b1;
        2'b01:   occ[c] <= occ[c] - 1'b1;
        default: occ[c] <= occ[c];
      endcase
    end

    assign room[c] = (occ[c] < CW'(quota_q[c])) || dec;
    assign zero[c] = (quota_q[c] == '0);

    // R5
    quota_cap_chk: assert property (@(posedge clk) disable iff (rst)
      occ[c] <= CW'(quota_q[c]));
    // R9
    occ_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      dec |-> (occ[c] != '0));
  end

  // R3
  sum_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && sum_bad) |=> $stable(quota_q));
endmodule

// File: rtl/xfer_queue_arb.sv
module xfer_queue_arb
  import xqa_pkg::*;
#(
  parameter int NUM_PRIO  = 4,
  parameter int DEPTH     = 16,
  parameter int TAG_W     = 32,
  parameter int MAX_SUM   = 16,
  parameter int RST_QUOTA = 5,
  parameter int PRIO_W    = $clog2(NUM_PRIO)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [PRIO_W-1:0]         req_prio,
  input  logic [CLS_W-1:0]          req_class,
  input  logic [TAG_W-1:0]          req_tag,
  output logic                      req_ready,
  input  logic                      cfg_we,
  input  logic [PRIO_W-1:0]         cfg_prio,
  input  logic [QCFG_W-1:0]         cfg_quota,
  output logic                      cfg_busy_rej,
  output logic                      cfg_sum_rej,
  output logic                      err_zero_quota,
  output logic [NUM_PRIO-1:0]       out_valid,
  input  logic [NUM_PRIO-1:0]       out_ready,
  output logic [NUM_PRIO*TAG_W-1:0] out_tag,
  output logic [NUM_PRIO*CLS_W-1:0] out_cls
);
  localparam int EW = CLS_W + TAG_W;

  logic [NUM_CLS-1:0] room_all [NUM_PRIO];
  logic [NUM_CLS-1:0] zero_all [NUM_PRIO];
  logic [NUM_PRIO-1:0] busy_v, sum_v;
  logic sel_room, sel_zero, cls_ok, adm_fire;

  always_comb begin
    sel_room = 1'b0;
    sel_zero = 1'b1;
    cls_ok   = 1'b0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (req_class == CLS_W'(c)) begin
        cls_ok   = 1'b1;
        sel_room = room_all[req_prio][c];
        sel_zero = zero_all[req_prio][c];
      end
    end
  end

  assign req_ready = cls_ok && sel_room;
  assign adm_fire  = req_valid && req_ready;

  for (genvar p = 0; p < NUM_PRIO; p++) begin : g_prio
    logic          push_p, pop_p, ne_p, full_p;
    logic [EW-1:0] head_p;

    assign push_p = adm_fire && (req_prio == PRIO_W'(p));
    assign pop_p  = ne_p && out_ready[p];

    xqa_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
      .clk(clk), .rst(rst), .push(push_p), .wdata({req_class, req_tag}),
      .pop(pop_p), .head(head_p), .nonempty(ne_p), .full(full_p)
    );

    xqa_quota #(.MAX_SUM(MAX_SUM), .RST_QUOTA(RST_QUOTA)) u_quota (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we && (cfg_prio == PRIO_W'(p))), .cfg_q(cfg_quota),
      .q_idle(!ne_p && !push_p),
      .adm_fire(push_p), .adm_cls(req_class),
      .dsp_fire(pop_p), .dsp_cls(head_p[EW-1 -: CLS_W]),
      .room(room_all[p]), .zero(zero_all[p]),
      .busy_hit(busy_v[p]), .sum_hit(sum_v[p])
    );

    assign out_valid[p]                = ne_p;
    assign out_tag[p*TAG_W +: TAG_W]   = head_p[TAG_W-1:0];
    assign out_cls[p*CLS_W +: CLS_W]   = head_p[EW-1 -: CLS_W];

    // R8
    port_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[p] && !out_ready[p]) |=>
        (out_valid[p] && $stable(out_tag[p*TAG_W +: TAG_W])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_busy_rej   <= 1'b0;
      cfg_sum_rej    <= 1'b0;
      err_zero_quota <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_busy_rej <= busy_v[cfg_prio];
        cfg_sum_rej  <= sum_v[cfg_prio];
      end
      if (req_valid && (!cls_ok || sel_zero)) err_zero_quota <= 1'b1;
    end
  end

  // R10
  zero_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_zero_quota |=> err_zero_quota);
  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && out_valid[cfg_prio]) |=> (cfg_busy_rej && !cfg_sum_rej));
  // R11
  bad_class_chk: assert property (@(posedge clk) disable iff (rst)
    (req_class == 2'd3) |-> !req_ready);
endmodule

// File: tb/xfer_queue_arb_test.sv
module xfer_queue_arb_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 0;
  logic [1:0]  req_prio = 0, req_class = 0, cfg_prio = 0;
  logic [31:0] req_tag = 0;
  logic        req_ready, cfg_we = 0, cfg_busy_rej, cfg_sum_rej, err_zero_quota;
  logic [8:0]  cfg_quota = 0;
  logic [3:0]  out_valid, out_ready = 0;
  logic [127:0] out_tag;
  logic [7:0]  out_cls;

  xfer_queue_arb uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_prio(req_prio),
    .req_class(req_class), .req_tag(req_tag), .req_ready(req_ready),
    .cfg_we(cfg_we), .cfg_prio(cfg_prio), .cfg_quota(cfg_quota),
    .cfg_busy_rej(cfg_busy_rej), .cfg_sum_rej(cfg_sum_rej),
    .err_zero_quota(err_zero_quota), .out_valid(out_valid),
    .out_ready(out_ready), .out_tag(out_tag), .out_cls(out_cls)
  );

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  int mcnt [4][3];
  int mquo [4][3];
  logic [33:0] mq [4][$];
  bit e_busy = 0, e_sum = 0, e_err = 0, last_rdy = 0;

  task automatic chk(input bit ok, input string name, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %0s act=%0h exp=%0h", name, act, exp);
    end
  endtask

  function automatic bit exp_ready(input logic [1:0] p, input logic [1:0] c,
                                   input logic [3:0] ordy, output bit via_free);
    via_free = 0;
    if (c == 2'd3) return 0;
    if (mcnt[p][c] < mquo[p][c]) return 1;
    if (ordy[p] && mq[p].size() > 0 && mq[p][0][33:32] == c) begin
      via_free = 1;
      return 1;
    end
    return 0;
  endfunction

  task automatic step(input bit v, input logic [1:0] p, input logic [1:0] c,
                      input logic [31:0] t, input logic [3:0] ordy,
                      input bit we, input logic [1:0] cp, input logic [8:0] cq);
    bit e, vf, adm, idle;
    int s;
    @(negedge clk);
    req_valid = v; req_prio = p; req_class = c; req_tag = t;
    out_ready = ordy; cfg_we = we; cfg_prio = cp; cfg_quota = cq;
    #1;
    e = exp_ready(p, c, ordy, vf);
    last_rdy = req_ready;
    chk(req_ready == e, vf ? "R6 same-cycle free" : "R5 ready", req_ready, e);
    for (int q = 0; q < 4; q++) begin
      chk(out_valid[q] == (mq[q].size() > 0), "R8 port valid", out_valid[q], mq[q].size() > 0);
      if (mq[q].size() > 0)
        chk({out_cls[q*2 +: 2], out_tag[q*32 +: 32]} == mq[q][0], "R7 order",
            {out_cls[q*2 +: 2], out_tag[q*32 +: 32]}, mq[q][0]);
    end
    chk(cfg_busy_rej == e_busy, "R4 busy bit", cfg_busy_rej, e_busy);
    chk(cfg_sum_rej == e_sum, "R3 sum bit", cfg_sum_rej, e_sum);
    chk(err_zero_quota == e_err, "R10 sticky error", err_zero_quota, e_err);
    adm = v && e;
    if (v && (c == 2'd3 || mquo[p][c] == 0)) e_err = 1;
    idle = (mq[cp].size() == 0) && !(adm && p == cp);
    for (int q = 0; q < 4; q++)
      if (ordy[q] && mq[q].size() > 0) begin
        mcnt[q][mq[q][0][33:32]]--;
        void'(mq[q].pop_front());
      end
    if (adm) begin
      mq[p].push_back({c, t});
      mcnt[p][c]++;
    end
    if (we) begin
      s = cq[2:0] + cq[5:3] + cq[8:6];
      e_busy = !idle;
      e_sum  = idle && (s > 16);
      if (idle && s <= 16) begin
        mquo[cp][0] = cq[2:0]; mquo[cp][1] = cq[5:3]; mquo[cp][2] = cq[8:6];
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int p = 0; p < 4; p++) for (int c = 0; c < 3; c++) begin
      mcnt[p][c] = 0; mquo[p][c] = 5;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk(out_valid == 4'b0, "R1 out_valid", out_valid, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk({err_zero_quota, cfg_busy_rej, cfg_sum_rej} == 3'b0, "R1 flags",
        {err_zero_quota, cfg_busy_rej, cfg_sum_rej}, 0);

    // R2: prio0 quotas 7,7,2 (sum 16)
    step(0, 0, 0, 0, 4'h0, 1, 2'd0, {3'd2, 3'd7, 3'd7});
    for (int i = 0; i < 7; i++) step(1, 0, 0, 32'h100 + i, 4'h0, 0, 0, 0);
    chk(e_busy == 0 && e_sum == 0, "R2 accepted", {e_busy, e_sum}, 0);
    step(1, 0, 0, 32'h1ff, 4'h0, 0, 0, 0);            // R5 stall at 7
    chk(last_rdy == 0, "R5 stall at quota", last_rdy, 0);
    step(1, 0, 0, 32'h200, 4'h1, 0, 0, 0);            // R6 freed same cycle
    chk(last_rdy == 1, "R6 admit on dispatch", last_rdy, 1);
    step(0, 0, 0, 0, 4'h1, 0, 0, 0);
    step(1, 0, 0, 32'h201, 4'h0, 0, 0, 0);
    chk(last_rdy == 1, "R9 freed slot", last_rdy, 1);

    // R4: write to nonempty prio0
    step(0, 0, 0, 0, 4'h0, 1, 2'd0, {3'd1, 3'd1, 3'd1});
    step(0, 0, 0, 0, 4'h0, 0, 0, 0);
    chk(cfg_busy_rej == 1, "R4 refused busy", cfg_busy_rej, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 4'hf, 0, 0, 0);

    // R3: sum 21 rejected
    step(0, 0, 0, 0, 4'h0, 1, 2'd1, {3'd7, 3'd7, 3'd7});
    step(0, 0, 0, 0, 4'h0, 0, 0, 0);
    chk(cfg_sum_rej == 1 && cfg_busy_rej == 0, "R3 refused sum", {cfg_sum_rej, cfg_busy_rej}, 2'b10);

    // R8: two ports dispatch together
    step(1, 1, 2, 32'hA1, 4'h0, 0, 0, 0);
    step(1, 3, 1, 32'hB1, 4'h0, 0, 0, 0);
    step(0, 0, 0, 0, 4'hA, 0, 0, 0);
    step(0, 0, 0, 0, 4'h0, 0, 0, 0);
    chk(out_valid == 4'b0, "R8 concurrent drain", out_valid, 0);

    // R10: quota 0 for class1 in prio2
    step(0, 0, 0, 0, 4'h0, 1, 2'd2, {3'd5, 3'd0, 3'd5});
    step(1, 2, 1, 32'hC0, 4'h0, 0, 0, 0);
    chk(last_rdy == 0, "R10 zero quota stall", last_rdy, 0);
    step(0, 0, 0, 0, 4'h0, 0, 0, 0);
    chk(err_zero_quota == 1, "R10 error raised", err_zero_quota, 1);

    // R11: class 3
    step(1, 0, 3, 32'hD0, 4'h0, 0, 0, 0);
    chk(last_rdy == 0, "R11 class 3 refused", last_rdy, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit w;
      w = ($urandom % 40) == 0;
      step($urandom % 3 != 0, 2'($urandom), 2'($urandom % 4 == 3 ? 2 : $urandom % 3),
           $urandom, 4'($urandom), w, 2'($urandom),
           {3'($urandom), 3'($urandom % 8), 3'($urandom)});
    end
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 4'hf, 0, 0, 0);
    chk(out_valid == 4'b0, "R7 drained", out_valid, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule